// File: doc/BRIEF.md
# Prescaled Core Watchdog Timer

This block is a watchdog for one processor core. Software sets it up with a single 64-bit control word that holds an operating mode, a 16-bit reload length and a 24-bit starting count. While the mode is nonzero, a free-running prescaler divides the clock by 1024, and each prescale tick lowers the count by one. When a tick finds the count already at zero, the block raises its expiry output. The output stays high until software acts.

Software keeps the timer from expiring by writing to a second register, the poke register, which has its own address. Any write there reloads the count with the length value placed in the upper 16 bits of the 24-bit counter, with the low 8 bits cleared. Writing an all-zero control word turns the watchdog off. Reading the control register returns the mode, the length and the live count.

The register port is a single-cycle port. It has a write strobe, a one-bit select between the control register and the poke register, 64-bit write data and 64-bit combinational read data.

Top module: `core_watchdog`

## Requirements
- R1: A write with select 0 (control) loads the mode from write-data bits 1:0, the length from bits 19:4 and the count from bits 43:20, all at the same clock edge; the other write-data bits have no effect.
- R2: While the mode is nonzero, the count drops by one on every 1024th rising clock edge. The first drop comes at the 1024th edge after the most recent control or poke write.
- R3: A write with select 1 (poke), whatever its data, sets the count to the length multiplied by 256, so the length fills count bits 23:8 and bits 7:0 are zero.
- R4: An all-zero control write disables the watchdog. With mode 0 the count does not change except through writes, the prescaler stays cleared and the expiry output stays low.
- R5: Each nonzero mode (1, 2 or 3) enables counting. Mode 3 is the normal armed setting.
- R6: A prescale tick that finds the count at zero raises the expiry output and leaves the count at zero. Expiry then stays high until the next control or poke write, which lowers it at that edge.
- R7: With select 0, read data shows the mode in bits 1:0, the length in bits 19:4 and the live count in bits 43:20, and every other bit reads zero. With select 1, read data is all zero.
- R8: Every control write and every poke write clears the prescaler, so a reload always gets a full 1024-cycle first tick period.
- R9: After reset, the mode, length, count and prescaler are zero and the expiry output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Single-cycle write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 poke |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the selected register |
| wd_expired | output | 1 | Expiry flag, held until a write |

## Verification
The bench targets four cases:

- **Tick spacing.** It times the first decrement after a write exactly. An off-by-one prescaler wrap shows up as a count that changes one cycle early or late.
- **Expiry from an armed count.** It lets the count run down to zero and then holds with no writes. A design that flags expiry on the 1-to-0 step, or that drops the flag by itself, disagrees with the model on the exact cycle.
- **Poke in mid-period, at the maximum length, and in mode 0.** A missing prescaler clear, a wrong shift or a poke that decrements while disabled each leaves a visibly different count.
- **Control words padded with set unused bits.** Any leakage of those bits into stored fields or read data appears in the read data.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int REG_W     = 64;
  localparam int MODE_W    = 2;
  localparam int LEN_W     = 16;
  localparam int CNT_W     = 24;
  localparam int MODE_LSB  = 0;
  localparam int LEN_LSB   = 4;
  localparam int CNT_LSB   = 20;
  localparam int LEN_SHIFT = CNT_W - LEN_W;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_POKE = 1'b1
  } wd_sel_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [LEN_W-1:0]  len;
  } wd_cfg_t;

  function automatic logic [CNT_W-1:0] reload_count(input logic [LEN_W-1:0] len);
    return {len, {LEN_SHIFT{1'b0}}};
  endfunction

  function automatic logic [MODE_W-1:0] get_mode(input logic [REG_W-1:0] w);
    return w[MODE_LSB +: MODE_W];
  endfunction

  function automatic logic [LEN_W-1:0] get_len(input logic [REG_W-1:0] w);
    return w[LEN_LSB +: LEN_W];
  endfunction

  function automatic logic [CNT_W-1:0] get_cnt(input logic [REG_W-1:0] w);
    return w[CNT_LSB +: CNT_W];
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input logic [MODE_W-1:0] mode,
                                                 input logic [LEN_W-1:0]  len,
                                                 input logic [CNT_W-1:0]  cnt);
    logic [REG_W-1:0] w;
    w = '0;
    w[MODE_LSB +: MODE_W] = mode;
    w[LEN_LSB +: LEN_W]   = len;
    w[CNT_LSB +: CNT_W]   = cnt;
    return w;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  sel,
  input  logic [REG_W-1:0]      wdata,
  output logic                  ctrl_wr,
  output logic                  poke_wr,
  output logic [CNT_W-1:0]      ctrl_cnt,
  output wd_cfg_t               cfg
);

  logic unused_wdata_bits;

  assign ctrl_wr  = wr_en && (wd_sel_e'(sel) == SEL_CTRL);
  assign poke_wr  = wr_en && (wd_sel_e'(sel) == SEL_POKE);
  assign ctrl_cnt = get_cnt(wdata);
  assign unused_wdata_bits = ^{wdata[REG_W-1:CNT_LSB+CNT_W], wdata[LEN_LSB-1:MODE_LSB+MODE_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (ctrl_wr) begin
      cfg.mode <= get_mode(wdata);
      cfg.len  <= get_len(wdata);
    end
  end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRESCALE_LOG2 = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);

  localparam logic [PRESCALE_LOG2-1:0] LAST = '1;

  logic [PRESCALE_LOG2-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clear || !run) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign tick = run && !clear && (pre_q == LAST);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expired,
  output logic             zero_hit
);

  assign zero_hit = tick && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (load) begin
      count   <= load_val;
      expired <= 1'b0;
    end else if (zero_hit) begin
      expired <= 1'b1;
    end else if (tick) begin
      count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/core_watchdog.sv
module core_watchdog
  import wdog_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             wd_expired
);

  logic             ctrl_wr;
  logic             poke_wr;
  logic [CNT_W-1:0] ctrl_cnt;
  wd_cfg_t          cfg;
  logic             run;
  logic             any_wr;
  logic             tick;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count;
  logic             expired;
  logic             zero_hit;

  wdog_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .ctrl_wr  (ctrl_wr),
    .poke_wr  (poke_wr),
    .ctrl_cnt (ctrl_cnt),
    .cfg      (cfg)
  );

  assign run      = (cfg.mode != '0);
  assign any_wr   = ctrl_wr || poke_wr;
  assign load_val = ctrl_wr ? ctrl_cnt : reload_count(cfg.len);

  wdog_prescaler #(.PRESCALE_LOG2(PRESCALE_LOG2)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clear (any_wr),
    .tick  (tick)
  );

  wdog_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (any_wr),
    .load_val (load_val),
    .tick     (tick),
    .count    (count),
    .expired  (expired),
    .zero_hit (zero_hit)
  );

  assign wd_expired = expired;
  assign reg_rdata  = (wd_sel_e'(reg_sel) == SEL_CTRL) ? pack_ctrl(cfg.mode, cfg.len, count) : '0;

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic             poke_wr,
  input logic [REG_W-1:0] wdata,
  input logic             tick,
  input logic             zero_hit,
  input logic [CNT_W-1:0] count,
  input logic [LEN_W-1:0] len,
  input logic [MODE_W-1:0] mode,
  input logic             expired,
  input logic [REG_W-1:0] rdata
);

  localparam int GAP_W = PRESCALE_LOG2 + 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'((1 << PRESCALE_LOG2) - 1);

  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0;
    end else if (ctrl_wr || poke_wr || mode == '0 || tick) begin
      gap <= '0;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  // R2 and R8: ticks come exactly one prescale period after a clear or a tick
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> gap == GAP_LAST);

  // R2: a tick on a nonzero count lowers it by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != '0) |=> count == $past(count) - 1'b1);

  // R1: a control write loads mode and count from their fields
  p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (mode == $past(wdata[1:0]) && count == $past(wdata[43:20])));

  // R3: a poke places the length in the upper count bits
  p_poke_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    poke_wr |=> count == {$past(len), 8'h00});

  // R4: with mode 0 nothing ticks and expiry stays low
  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == '0) |-> (!tick && !expired));

  // R6: a tick at zero raises expiry
  p_expiry_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> expired);

  // R6: expiry holds until a write
  p_expiry_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !ctrl_wr && !poke_wr) |=> expired);

  // R7: unused read bits are zero
  p_rdata_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[63:44] == '0 && rdata[3:2] == '0));

endmodule

bind core_watchdog wdog_checker #(.PRESCALE_LOG2(PRESCALE_LOG2)) u_wdog_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_wr  (ctrl_wr),
  .poke_wr  (poke_wr),
  .wdata    (reg_wdata),
  .tick     (tick),
  .zero_hit (zero_hit),
  .count    (count),
  .len      (cfg.len),
  .mode     (cfg.mode),
  .expired  (expired),
  .rdata    (reg_rdata)
);

// File: tb/tb_core_watchdog.sv
module tb_core_watchdog;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        wd_expired;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;
  string phase = "R9 reset";

  // behavioural reference state
  longint unsigned m_mode = 0, m_len = 0, m_cnt = 0;
  int m_pre = 0;
  bit m_exp = 0;

  always #4 clk = ~clk;

  core_watchdog dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .wd_expired (wd_expired)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_len = 0; m_cnt = 0; m_pre = 0; m_exp = 0;
      started = 1;
    end else if (reg_wr_en && !reg_sel) begin
      m_mode = reg_wdata & 64'h3;
      m_len  = (reg_wdata >> 4) & 64'hFFFF;
      m_cnt  = (reg_wdata >> 20) & 64'hFF_FFFF;
      m_pre  = 0;
      m_exp  = 0;
    end else if (reg_wr_en && reg_sel) begin
      m_cnt = m_len * 256;
      m_pre = 0;
      m_exp = 0;
    end else if (m_mode != 0) begin
      if (m_pre == 1023) begin
        m_pre = 0;
        if (m_cnt == 0) m_exp = 1;
        else m_cnt = m_cnt - 1;
      end else begin
        m_pre = m_pre + 1;
      end
    end
  end

  always @(negedge clk) begin
    longint unsigned exp_word;
    if (started && !done) begin
      exp_word = reg_sel ? 64'd0 : (m_cnt * 64'd1048576 + m_len * 64'd16 + m_mode);
      n_cmp++;
      if (reg_rdata !== exp_word) begin
        n_bad++;
        $display("FAIL %s: rdata actual %h expected %h at %0t", phase, reg_rdata, exp_word, $time);
      end
      n_cmp++;
      if (wd_expired !== m_exp) begin
        n_bad++;
        $display("FAIL %s: expired actual %0b expected %0b at %0t", phase, wd_expired, m_exp, $time);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(input bit sel, input logic [63:0] d);
    @(posedge clk); #2;
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr_en = 1'b0; reg_sel = 1'b0; reg_wdata = 64'h5A5A_A5A5_5A5A_A5A5;
  endtask

  function automatic logic [63:0] ctrl(input int mode, input int len, input int cnt);
    return (64'(cnt) << 20) | (64'(len) << 4) | 64'(mode);
  endfunction

  initial begin
    int wd_cycles;
    wd_cycles = 0;
    while (!done && wd_cycles < 100000) begin
      @(posedge clk);
      wd_cycles++;
    end
    if (!done) begin
      done = 1;
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", wd_cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    idle(4); #2; rst_n = 1'b1;
    idle(3);
    // R1 R2 R6: arm with count 3, run to expiry
    phase = "R1 R2 R6 arm mode 3";
    wr(1'b0, ctrl(3, 1, 3));
    idle(4 * 1024 + 600);
    phase = "R6 expiry held";
    idle(300);
    // R3 R8: poke reloads and restarts the prescale period
    phase = "R3 R8 poke";
    wr(1'b1, 64'h0000_0000_0000_1234);
    idle(700);
    wr(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    idle(1500);
    // R7 R1: unused bits set in control word, mode 2 (R5)
    phase = "R7 R1 R5 padded control mode 2";
    wr(1'b0, 64'hFFFF_F000_0000_000C | ctrl(2, 16'h00AB, 5));
    idle(20);
    @(posedge clk); #2; reg_sel = 1'b1;
    phase = "R7 poke select reads zero";
    idle(10);
    @(posedge clk); #2; reg_sel = 1'b0;
    phase = "R5 mode 2 run";
    idle(2100);
    // R5: mode 1 counts and expires
    phase = "R5 mode 1";
    wr(1'b0, ctrl(1, 2, 2));
    idle(3500);
    // R4: disable and freeze
    phase = "R4 all-zero disable";
    wr(1'b0, 64'd0);
    idle(2100);
    wr(1'b0, ctrl(0, 7, 9));
    idle(2100);
    phase = "R4 poke while off";
    wr(1'b1, 64'd0);
    idle(2100);
    // R3 R6: maximum length
    phase = "R3 R6 max length";
    wr(1'b0, ctrl(3, 16'hFFFF, 0));
    idle(1100);
    wr(1'b1, 64'd1);
    idle(2100);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule